// File: doc/BRIEF.md
# Dual-Channel Peak Magnitude Hold

This block watches two independent signed sample streams, one carrying a voltage waveform and one carrying a current waveform, and keeps for each the largest magnitude seen so far in a 16-bit unsigned register. Every time a stream presents a valid sample, the block converts the sample to its magnitude. It overwrites that stream's register only when the new magnitude is strictly larger than the one held.

Software or a neighbouring controller reads the held peaks through a simple read port: a one-cycle read strobe with a 2-bit address and a registered data return. Each peak can be read at two addresses. The plain address leaves the register untouched. The alias address returns the held value and then zeroes the register, which starts a fresh measurement window. The address decode is fixed: bit 0 selects the channel (0 = voltage, 1 = current), and bit 1 selects clear-on-read (0 = plain, 1 = clear). Addresses 0 and 1 are the plain voltage and current peaks. Addresses 2 and 3 are their clear-on-read aliases.

Top module: `peak_hold_regs`

## Requirements
- R1: While `rst` is high at a rising clock edge, both peak registers, `rd_data` and `rd_valid` are set to zero.
- R2: A sample is taken as 16-bit two's complement, and its magnitude is its absolute value. The most negative code 0x8000 has magnitude 0x8000 (so 0x8000 is larger than 0x7FFF).
- R3: A peak register takes a new value only on a cycle where its stream's valid strobe is high and the sample magnitude is strictly greater than the held value. An equal or smaller magnitude, or any sample presented with valid low, leaves the register unchanged.
- R4: The voltage stream updates only the voltage peak, and the current stream updates only the current peak.
- R5: A read at address 0 (voltage) or 1 (current) returns the held peak and leaves it unchanged.
- R6: A read at address 2 (voltage) or 3 (current) returns the peak held before the read edge, and the register holds zero after that edge.
- R7: If a clear-on-read of a channel coincides with a valid sample on that channel, the register holds that sample's magnitude after the edge instead of zero. The read still returns the value held before the edge.
- R8: `rd_valid` is high for exactly the cycle after the `rd_en` cycle, and `rd_data` then shows the value the addressed peak held before that edge.
- R9: A clear-on-read of one channel leaves the other channel's peak unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| v_valid | input | 1 | Voltage sample strobe |
| v_sample | input | 16 | Voltage sample, two's complement |
| i_valid | input | 1 | Current sample strobe |
| i_sample | input | 16 | Current sample, two's complement |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_addr | input | 2 | Read address: bit 0 channel, bit 1 clear-on-read |
| rd_data | output | 16 | Registered read data |
| rd_valid | output | 1 | High the cycle after a read |

## Verification
A table of samples walks both channels through rising, equal and smaller magnitudes of both signs. This separates a strict comparison from a non-strict one, and a true absolute value from a raw signed compare. The table includes 0x7FFF, 0x8001 and 0x8000, which expose the wrong handling of the most negative code. Interleaving the two channels shows whether one stream leaks into the other's register. Directed steps then cover the following: samples with the strobe low; a plain read against an alias read; an alias read on one channel while the other is checked; an alias read coinciding with a sample; and a reset in the middle of a run.

// File: rtl/pkh_pkg.sv
package pkh_pkg;
  // Number of tracked streams; the read address is {clear, channel}.
  localparam int unsigned PKH_NCH = 2;
  localparam int unsigned PKH_CW  = $clog2(PKH_NCH);
  localparam int unsigned PKH_AW  = PKH_CW + 1;

  typedef enum logic [PKH_AW-1:0] {
    PKH_RD_VOLT     = 2'd0,
    PKH_RD_CURR     = 2'd1,
    PKH_RD_VOLT_CLR = 2'd2,
    PKH_RD_CURR_CLR = 2'd3
  } pkh_addr_e;
endpackage

// File: rtl/pkh_abs.sv
module pkh_abs #(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] smp,
  output logic [DW-1:0] mag
);
  localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};

  // Two's complement negate; the most negative code maps onto itself,
  // which read as unsigned is exactly its magnitude.
  always_comb begin
    if (smp[DW-1]) mag = (~smp) + 1'b1;
    else           mag = smp;
  end

  // R2: a magnitude with its top bit set can only come from the most negative code
  always_comb begin
    if (mag[DW-1]) p_msb_only_most_neg_r2: assert (smp == MOST_NEG);
  end
endmodule

// File: rtl/pkh_tracker.sv
module pkh_tracker #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vld,
  input  logic [DW-1:0] mag,
  input  logic          clr,
  output logic [DW-1:0] peak
);
  logic bigger;
  assign bigger = vld && (mag > peak);

  always_ff @(posedge clk) begin
    if (rst)         peak <= '0;
    else if (clr)    peak <= vld ? mag : '0;
    else if (bigger) peak <= mag;
  end

  p_no_drop_r3: assert property (@(posedge clk) disable iff (rst)
    !clr |=> peak >= $past(peak));
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (!clr && !vld) |=> $stable(peak));
  p_clear_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (clr && !vld) |=> peak == '0);
  p_clear_keeps_sample_r7: assert property (@(posedge clk) disable iff (rst)
    (clr && vld) |=> peak == $past(mag));
endmodule

// File: rtl/pkh_rdport.sv
module pkh_rdport #(
  parameter int unsigned DW  = 16,
  parameter int unsigned NCH = 2,
  parameter int unsigned CW  = 1,
  parameter int unsigned AW  = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_en,
  input  logic [AW-1:0]          rd_addr,
  input  logic [NCH-1:0][DW-1:0] peaks,
  output logic [NCH-1:0]         clr_req,
  output logic [DW-1:0]          rd_data,
  output logic                   rd_valid
);
  logic [CW-1:0] sel;
  logic          is_clr;
  assign sel    = rd_addr[CW-1:0];
  assign is_clr = rd_addr[AW-1];

  for (genvar c = 0; c < NCH; c++) begin : g_clr
    assign clr_req[c] = rd_en && is_clr && (sel == CW'(c));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= peaks[sel];
    end
  end

  p_one_clear_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(clr_req));
  p_rd_valid_r8: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  p_rd_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
endmodule

// File: rtl/peak_hold_regs.sv
module peak_hold_regs
  import pkh_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 v_valid,
  input  logic [DW-1:0]        v_sample,
  input  logic                 i_valid,
  input  logic [DW-1:0]        i_sample,
  input  logic                 rd_en,
  input  logic [PKH_AW-1:0]    rd_addr,
  output logic [DW-1:0]        rd_data,
  output logic                 rd_valid
);
  logic [PKH_NCH-1:0]         vld;
  logic [PKH_NCH-1:0][DW-1:0] smp;
  logic [PKH_NCH-1:0][DW-1:0] mag;
  logic [PKH_NCH-1:0][DW-1:0] peaks;
  logic [PKH_NCH-1:0]         clr_req;

  assign vld = {i_valid, v_valid};
  assign smp = {i_sample, v_sample};

  for (genvar c = 0; c < PKH_NCH; c++) begin : g_ch
    pkh_abs #(.DW(DW)) u_abs (
      .smp (smp[c]),
      .mag (mag[c])
    );
    pkh_tracker #(.DW(DW)) u_trk (
      .clk  (clk),
      .rst  (rst),
      .vld  (vld[c]),
      .mag  (mag[c]),
      .clr  (clr_req[c]),
      .peak (peaks[c])
    );
    // R4: a channel with no strobe and no clear keeps its peak
    p_chan_isolated_r4: assert property (@(posedge clk) disable iff (rst)
      (!vld[c] && !clr_req[c]) |=> $stable(peaks[c]));
  end

  pkh_rdport #(.DW(DW), .NCH(PKH_NCH), .CW(PKH_CW), .AW(PKH_AW)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .peaks    (peaks),
    .clr_req  (clr_req),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  p_read_returns_peak_r5: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_data == $past(peaks[rd_addr[PKH_CW-1:0]]));
endmodule

// File: tb/tb_peak_hold_regs.sv
module tb_peak_hold_regs;
  logic        clk = 1'b0;
  logic        rst;
  logic        v_valid, i_valid, rd_en;
  logic [15:0] v_sample, i_sample;
  logic [1:0]  rd_addr;
  logic [15:0] rd_data;
  logic        rd_valid;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  peak_hold_regs dut (
    .clk(clk), .rst(rst), .v_valid(v_valid), .v_sample(v_sample),
    .i_valid(i_valid), .i_sample(i_sample), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // {channel (0 volt, 1 curr), sample, expected peak of that channel}
  localparam int NV = 10;
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 16'h0010, 16'h0010},
    {1'b0, 16'hFFF0, 16'h0010},
    {1'b0, 16'hFFEF, 16'h0011},
    {1'b1, 16'h1234, 16'h1234},
    {1'b0, 16'h0005, 16'h0011},
    {1'b1, 16'h8000, 16'h8000},
    {1'b1, 16'h7FFF, 16'h8000},
    {1'b0, 16'h7FFF, 16'h7FFF},
    {1'b0, 16'h8001, 16'h7FFF},
    {1'b0, 16'h8000, 16'h8000}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sample(input logic ch, input logic [15:0] val, input logic strobe);
    @(negedge clk);
    if (ch) begin i_sample = val; i_valid = strobe; end
    else    begin v_sample = val; v_valid = strobe; end
    @(negedge clk);
    v_valid = 1'b0; i_valid = 1'b0;
  endtask

  task automatic read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check("R8 rd_valid", {15'd0, rd_valid}, 16'd1);
    d = rd_data;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    rst = 1'b1; v_valid = 0; i_valid = 0; rd_en = 0; rd_addr = 0;
    v_sample = 0; i_sample = 0;
    repeat (3) @(negedge clk);
    check("R1 rd_data", rd_data, 16'h0);
    check("R1 rd_valid", {15'd0, rd_valid}, 16'h0);
    rst = 1'b0;
    read(2'd0, d); check("R1 volt peak", d, 16'h0);
    read(2'd1, d); check("R1 curr peak", d, 16'h0);
    @(negedge clk);
    check("R8 rd_valid drops", {15'd0, rd_valid}, 16'h0);

    // table walk: R2 magnitude, R3 strict compare, R4 isolation, R5 plain read
    for (int k = 0; k < NV; k++) begin
      sample(VEC[k][32], VEC[k][31:16], 1'b1);
      read({1'b0, VEC[k][32]}, d);
      check($sformatf("R2/R3/R5 vec %0d", k), d, VEC[k][15:0]);
    end
    read(2'd1, d); check("R4 curr untouched", d, 16'h8000);

    // R3: sample with strobe low is ignored
    sample(1'b0, 16'h0001, 1'b0);
    read(2'd2, d); check("R6 clear read value", d, 16'h8000);
    read(2'd0, d); check("R6 cleared", d, 16'h0);
    read(2'd1, d); check("R9 other kept", d, 16'h8000);
    sample(1'b0, 16'h7000, 1'b0);
    read(2'd0, d); check("R3 strobe low ignored", d, 16'h0);
    read(2'd1, d); check("R5 plain read no clear", d, 16'h8000);

    // R7: clear-on-read coincides with a valid sample
    sample(1'b1, 16'hFF00, 1'b1);
    read(2'd1, d); check("R3 smaller kept", d, 16'h8000);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 2'd3; i_valid = 1'b1; i_sample = 16'hFF00;
    @(negedge clk);
    rd_en = 1'b0; i_valid = 1'b0;
    check("R7 read returns old", rd_data, 16'h8000);
    read(2'd1, d); check("R7 sample magnitude kept", d, 16'h0100);

    // R1: reset mid-run
    sample(1'b0, 16'h0042, 1'b1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    read(2'd0, d); check("R1 volt after reset", d, 16'h0);
    read(2'd1, d); check("R1 curr after reset", d, 16'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule